// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This block gathers seven single-cycle event pulses from an audio codec into sticky pending flags. It also holds a per-source mask and an interrupt control byte, and from these it drives one interrupt line toward the processor. Software reaches the three registers through a small 8-bit register port with an address, a write enable, write data and combinational read data. It clears a pending flag by writing a 1 to its bit.

The interrupt line has four forms, chosen by the two top bits of the control byte. Two are level forms that follow "any unmasked flag pending", one active high and one active low. Two are pulse forms that mark the arrival of a new unmasked flag with a single cycle, one high and one low. A mask bit only hides a source from the interrupt line: the flag itself still records the event.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset the control register reads 0x00, the mask register reads 0xFF, the flag register reads 0x00 and the interrupt output is low.
- R2: An event pulse on evtIn bit i sets flag bit i, visible from the cycle after the pulse. The bits are 6 short-circuit clear, 5 jack, 4 short-circuit mic, 3 ramp-up done, 2 ramp-down done, 1 gain-up done and 0 gain-down done. A set flag stays set until it is cleared.
- R3: Writing the flag register (address 0x06) clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged. Writing 0x7F clears all flags.
- R4: When an event pulse and a write-1 clear reach the same flag bit in the same cycle, the flag ends up set.
- R5: A 1 in mask register bit i (address 0x05, same bit positions as the flags, 0x7F masks every source) keeps source i off the interrupt output. It does not stop flag i from setting.
- R6: With control bits 7:6 = 00 (address 0x04), the output is high exactly while at least one unmasked flag is pending.
- R7: With form 01 the output is the inverse of the form 00 level: it is low while an unmasked flag is pending and high otherwise.
- R8: With form 10 the output is high for exactly one cycle, the cycle after an event sets a previously clear, unmasked flag. An event on an already set flag, or unmasking a pending flag, gives no pulse.
- R9: With form 11 the output idles high and drops low for one cycle under the same conditions that make a form 10 pulse.
- R10: A write to any other address changes no register, and a read from any other address returns 0x00. Flag register bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register (combinational) |
| evtIn | input | 7 | One-cycle event pulses, one per source |
| irqOut | output | 1 | Interrupt output in the selected form |

## Verification
The assertions assume that every evtIn bit is a clean synchronous pulse that is never X after reset. They also assume that a write presents its address and data in the same cycle as regWrEn. The stimulus drives every input only between clock edges, holds evtIn at zero outside deliberate one-cycle pulses, and raises regWrEn only for single-cycle writes with stable address and data. One case deliberately drives an event and a clear of the same bit in the same cycle, to exercise the priority rule without breaking these assumptions.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  // Output form selected by the top two bits of the control register.
  typedef enum logic [1:0] {
    FORM_LVL_HI = 2'b00,
    FORM_LVL_LO = 2'b01,
    FORM_PLS_HI = 2'b10,
    FORM_PLS_LO = 2'b11
  } irq_form_e;

  // Strobes from the address decoder to the register datapath.
  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrFlag;
    logic selCtrl;
    logic selMask;
    logic selFlag;
  } reg_strb_t;

endpackage

// File: rtl/cirq_decode.sv
module cirq_decode
  import cirq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h05,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h06
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output reg_strb_t         strb
);

  logic hitCtrl, hitMask, hitFlag;

  assign hitCtrl = (regAddr == CTRL_ADDR);
  assign hitMask = (regAddr == MASK_ADDR);
  assign hitFlag = (regAddr == FLAG_ADDR);

  always_comb begin
    strb.selCtrl = hitCtrl;
    strb.selMask = hitMask;
    strb.selFlag = hitFlag;
    strb.wrCtrl  = regWrEn && hitCtrl;
    strb.wrMask  = regWrEn && hitMask;
    strb.wrFlag  = regWrEn && hitFlag;
  end

endmodule

// File: rtl/cirq_datapath.sv
module cirq_datapath
  import cirq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  reg_strb_t          strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  localparam int FORM_LSB = DATA_W - 2;
  localparam int PAD_W    = DATA_W - NUM_SRC;

  logic [DATA_W-1:0]  ctrlQ;
  logic [DATA_W-1:0]  maskQ;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] flagD;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] srcMask;
  logic               pulseQ;
  logic               newUnmasked;
  logic               pending;
  irq_form_e          form;

  assign clrVec  = strb.wrFlag ? wrData[NUM_SRC-1:0] : '0;
  assign srcMask = maskQ[NUM_SRC-1:0];
  assign form    = irq_form_e'(ctrlQ[FORM_LSB +: 2]);

  // Per-source flag update: a new event takes priority over a clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign flagD[i] = evtIn[i] | (flagQ[i] & ~clrVec[i]);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> flagQ[i]);                                    // R4
    AST_CLR_W1C: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrFlag && wrData[i] && !evtIn[i]) |=> !flagQ[i]);    // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[i] && !(strb.wrFlag && wrData[i])) |=> flagQ[i]);   // R2
  end

  assign newUnmasked = |(evtIn & ~flagQ & ~srcMask);
  assign pending     = |(flagQ & ~srcMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      maskQ  <= '1;
      flagQ  <= '0;
      pulseQ <= 1'b0;
    end else begin
      if (strb.wrCtrl) ctrlQ <= wrData;
      if (strb.wrMask) maskQ <= wrData;
      flagQ  <= flagD;
      pulseQ <= newUnmasked;
    end
  end

  always_comb begin
    unique case (form)
      FORM_LVL_HI: irqOut = pending;
      FORM_LVL_LO: irqOut = ~pending;
      FORM_PLS_HI: irqOut = pulseQ;
      default:     irqOut = ~pulseQ;
    endcase
  end

  always_comb begin
    rdData = '0;
    if (strb.selCtrl)      rdData = ctrlQ;
    else if (strb.selMask) rdData = maskQ;
    else if (strb.selFlag) rdData = {{PAD_W{1'b0}}, flagQ};
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (srcMask == '1 && form == FORM_LVL_HI) |-> !irqOut);          // R5
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (form == FORM_PLS_HI && irqOut) |-> $past(|evtIn));           // R8
  AST_LOWPULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (form == FORM_PLS_LO && !irqOut) |-> $past(|evtIn));          // R9

endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
  import cirq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h05,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h06
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic               irqOut
);

  reg_strb_t strb;

  cirq_decode #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .MASK_ADDR(MASK_ADDR),
    .FLAG_ADDR(FLAG_ADDR)
  ) i_decode (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strb   (strb)
  );

  cirq_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(regWrData),
    .evtIn (evtIn),
    .rdData(regRdData),
    .irqOut(irqOut)
  );

endmodule

// File: tb/test_codec_irq_unit.sv
module test_codec_irq_unit;

  localparam logic [4:0] A_CTRL = 5'h04;
  localparam logic [4:0] A_MASK = 5'h05;
  localparam logic [4:0] A_FLAG = 5'h06;
  localparam logic [4:0] A_NONE = 5'h07;

  typedef struct {
    bit       isIrq;
    bit [7:0] exp;
    string    req;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [6:0] evtIn = '0;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  sb_item_t sbQ[$];

  always #2.5 clk = ~clk;

  codec_irq_unit #(
    .ADDR_W(5), .DATA_W(8), .NUM_SRC(7),
    .CTRL_ADDR(A_CTRL), .MASK_ADDR(A_MASK), .FLAG_ADDR(A_FLAG)
  ) i_codec_irq_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn),
    .irqOut(irqOut)
  );

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() > 0) begin
        sb_item_t it;
        it = sbQ.pop_front();
        nChecks++;
        if (it.isIrq) begin
          if (irqOut !== it.exp[0]) begin
            nFails++;
            $display("FAIL %s irqOut actual=%0b expected=%0b", it.req, irqOut, it.exp[0]);
          end
        end else if (regRdData !== it.exp) begin
          nFails++;
          $display("FAIL %s regRdData actual=%02h expected=%02h", it.req, regRdData, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
    settle();
  endtask

  task automatic evt(input logic [6:0] v);
    evtIn = v;
    tick();
    evtIn = '0;
  endtask

  task automatic expRd(input logic [4:0] a, input logic [7:0] e, input string req);
    sb_item_t it;
    regAddr = a;
    it.isIrq = 1'b0; it.exp = e; it.req = req;
    sbQ.push_back(it);
    settle();
  endtask

  task automatic expIrq(input bit e, input string req);
    sb_item_t it;
    it.isIrq = 1'b1; it.exp = {7'd0, e}; it.req = req;
    sbQ.push_back(it);
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    settle();

    // R1: reset values
    expRd(A_CTRL, 8'h00, "R1");
    expRd(A_MASK, 8'hFF, "R1");
    expRd(A_FLAG, 8'h00, "R1");
    expIrq(1'b0, "R1");

    // R5: all masked, flags still set, no interrupt
    evt(7'h7F);
    expRd(A_FLAG, 8'h7F, "R5");
    expIrq(1'b0, "R5");

    // R3: write-1 clear, write-0 no effect, clear all
    wr(A_FLAG, 8'h05);
    expRd(A_FLAG, 8'h7A, "R3");
    wr(A_FLAG, 8'h00);
    expRd(A_FLAG, 8'h7A, "R3");
    wr(A_FLAG, 8'h7F);
    expRd(A_FLAG, 8'h00, "R3");

    // R2: each source sets its own bit and stays set
    for (int i = 0; i < 7; i++) begin
      evt(7'(1 << i));
      settle();
      tick();
      expRd(A_FLAG, 8'(1 << i), "R2");
      wr(A_FLAG, 8'h7F);
    end

    // R6: level-high form
    wr(A_MASK, 8'h00);
    expIrq(1'b0, "R6");
    evt(7'h08);
    expIrq(1'b1, "R6");
    tick();
    expIrq(1'b1, "R6");
    // R5: masking the pending source drops the output, flag remains
    wr(A_MASK, 8'h08);
    expIrq(1'b0, "R5");
    expRd(A_FLAG, 8'h08, "R5");
    wr(A_MASK, 8'h00);
    wr(A_FLAG, 8'h7F);
    expIrq(1'b0, "R3");

    // R4: event and clear on the same bit in one cycle
    evt(7'h0C);
    settle();
    regAddr = A_FLAG; regWrData = 8'h0C; regWrEn = 1'b1; evtIn = 7'h04;
    tick();
    regWrEn = 1'b0; evtIn = '0;
    settle();
    expRd(A_FLAG, 8'h04, "R4");
    wr(A_FLAG, 8'h7F);

    // R7: level-low form
    wr(A_CTRL, 8'h40);
    expRd(A_CTRL, 8'h40, "R7");
    expIrq(1'b1, "R7");
    evt(7'h01);
    expIrq(1'b0, "R7");
    wr(A_FLAG, 8'h7F);
    expIrq(1'b1, "R7");

    // R8: high pulse form
    wr(A_CTRL, 8'h80);
    expIrq(1'b0, "R8");
    evt(7'h02);
    expIrq(1'b1, "R8");
    tick();
    expIrq(1'b0, "R8");
    evt(7'h02);
    expIrq(1'b0, "R8");
    wr(A_MASK, 8'h10);
    evt(7'h10);
    expIrq(1'b0, "R8");
    wr(A_MASK, 8'h00);
    expIrq(1'b0, "R8");
    tick();
    expIrq(1'b0, "R8");
    wr(A_FLAG, 8'h7F);

    // R9: low pulse form
    wr(A_CTRL, 8'hC0);
    expIrq(1'b1, "R9");
    evt(7'h20);
    expIrq(1'b0, "R9");
    tick();
    expIrq(1'b1, "R9");
    wr(A_FLAG, 8'h7F);

    // R10: unmapped address
    wr(A_NONE, 8'hFF);
    expRd(A_NONE, 8'h00, "R10");
    expRd(A_CTRL, 8'hC0, "R10");
    expRd(A_MASK, 8'h00, "R10");
    wr(A_FLAG, 8'hFF);
    expRd(A_FLAG, 8'h00, "R10");

    tick();
    settle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule